// File: doc/BRIEF.md
# Circuit-Switched Source Handshake Controller

This block sits between a source core and its interface router on a circuit-switched on-chip network. It takes one transfer request at a time. Each request carries a target core address, a payload length and a retry policy. The block sends a one-cycle setup packet that holds both the target address and the block's own source address. It then waits for the target to report that the whole circuit exists. After that it streams the payload words with a data-valid line held high. When the last word has gone out, data-valid drops and the block raises a one-cycle release strobe, which is the teardown request. No packet is needed for teardown.

If the network reports a blocked path while the block waits for the circuit, the latched retry policy decides what happens next. In intermittent mode the block releases the partial circuit, counts down a programmable back-off, and sends the setup packet again. In persistent mode the block leaves the partial circuit in place and keeps waiting until ready arrives. This mode suits high-priority transfers. An attempt counter reports how many setup packets the current transfer needed. The block holds no payload storage: each word passes straight from the producer to the network in the cycle it is taken.

Top module: `circ_src_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `attempts` is 0, and `net_setup`, `net_valid`, `net_release`, `pay_take` and `done` are all 0.
- R2: A request is accepted only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the transfer has finished. A request presented while `req_ready` is low is ignored and is not queued.
- R3: In the cycle after acceptance, `net_setup` is high for exactly one cycle. During that cycle `net_data[2*ADDR_W-1:ADDR_W]` holds the target, `net_data[ADDR_W-1:0]` holds `SRC_ADDR`, and the upper bits are zero.
- R4: No payload is sent before ready. `net_valid` first rises in the cycle after `net_ready` is sampled high while the block is waiting for the circuit.
- R5: The payload phase lasts exactly `req_len` consecutive cycles, or 1 cycle when `req_len` is 0. In each of those cycles `net_valid` and `pay_take` are high and `net_data` equals `pay_data`.
- R6: In the cycle after the last payload word, `net_valid` is low, and `net_release` and `done` are both high for one cycle. In the following cycle `req_ready` is 1.
- R7: In intermittent mode (`req_persist`=0), a blocked indication sampled while waiting leads to the following, with `done` held low throughout:
  - a one-cycle `net_release` in the next cycle;
  - then `req_backoff`+1 quiet cycles;
  - then a new one-cycle setup packet.
- R8: In persistent mode (`req_persist`=1), `net_blocked` is ignored. There is no release and no new setup, and the block keeps waiting until `net_ready` arrives.
- R9: When `net_ready` and `net_blocked` are sampled high in the same waiting cycle, the payload starts and no release occurs.
- R10: `attempts` becomes 1 in the first setup cycle. It increases by 1 with each retried setup and saturates at 2^CNT_W-1. It keeps its value after `done` until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block is idle and will take a request |
| req_target | input | ADDR_W | Target core address |
| req_len | input | LEN_W | Payload word count (0 treated as 1) |
| req_persist | input | 1 | 1 = persistent mode, 0 = intermittent mode |
| req_backoff | input | DLY_W | Back-off length for intermittent retries |
| pay_data | input | DATA_W | Payload word from the producer |
| pay_take | output | 1 | Payload word consumed this cycle |
| net_data | output | DATA_W | Setup packet or payload word toward the router |
| net_setup | output | 1 | Setup packet present on `net_data` |
| net_valid | output | 1 | Data-valid for payload words |
| net_release | output | 1 | Teardown strobe for the circuit |
| net_ready | input | 1 | Target reports the circuit is complete |
| net_blocked | input | 1 | Network reports the path is blocked |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| attempts | output | CNT_W | Setup packets sent for the current transfer |

## Verification
Every output is decoded from a registered state, so each result is due exactly one clock edge after the stimulus that causes it:
- the setup packet, one edge after acceptance;
- the first payload word, one edge after ready is sampled;
- the release, one edge after the last word or after a blocked sample;
- the retried setup, `req_backoff`+1 cycles after the back-off begins.

The bench changes inputs and reads outputs one time unit after each rising edge. It counts edges from the stimulus to the expected result, so every compare falls in the exact cycle the requirement names. It does not poll for a result. Ignored inputs (a blocked indication in persistent mode, a refused request) are judged by the outputs in the cycles that follow them.

// File: rtl/circ_src_pkg.sv
// Shared types for the circuit-switched source controller.
package circ_src_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND_SETUP,
        ST_WAIT_READY,
        ST_PAYLOAD,
        ST_TEARDOWN,
        ST_BACKOFF
    } src_state_t;
endpackage

// File: rtl/circ_src_fsm.sv
// Handshake sequencer for one transfer.
// Assumes: start is only pulsed in ST_IDLE; last_word and wait_over are
// valid in the states that use them.
module circ_src_fsm
    import circ_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       net_ready,
    input  logic       net_blocked,
    input  logic       persist,
    input  logic       last_word,
    input  logic       wait_over,
    output src_state_t state,
    output logic       retry_pending
);
    src_state_t nxt;

    // Next-state selection; ready wins over blocked.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (start) nxt = ST_SEND_SETUP;
            ST_SEND_SETUP: nxt = ST_WAIT_READY;
            ST_WAIT_READY: begin
                if (net_ready)                    nxt = ST_PAYLOAD;
                else if (net_blocked && !persist) nxt = ST_TEARDOWN;
            end
            ST_PAYLOAD:    if (last_word) nxt = ST_TEARDOWN;
            ST_TEARDOWN:   nxt = retry_pending ? ST_BACKOFF : ST_IDLE;
            ST_BACKOFF:    if (wait_over) nxt = ST_SEND_SETUP;
            default:       nxt = ST_IDLE;
        endcase
    end

    // State register plus the flag marking a teardown that precedes a retry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            retry_pending <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_WAIT_READY && nxt == ST_TEARDOWN)
                retry_pending <= 1'b1;
            else if (state == ST_TEARDOWN)
                retry_pending <= 1'b0;
        end
    end
endmodule

// File: rtl/circ_src_lencnt.sv
// Payload word counter: stores the requested length at acceptance and counts
// the words of the payload phase. A length of zero behaves as one word.
module circ_src_lencnt #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [LEN_W-1:0] len_in,
    input  logic             load,
    input  logic             step,
    output logic             last_word
);
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] remain;

    // Holds the length across retries and reloads it at payload start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            remain <= '0;
        end else begin
            if (capture) len_q <= len_in;
            if (load)
                remain <= len_q;
            else if (step && remain > 1)
                remain <= remain - 1'b1;
        end
    end

    assign last_word = (remain <= 1);
endmodule

// File: rtl/circ_src_backoff.sv
// Back-off down-counter: loads the delay when a retry teardown ends and
// reports expiry once it reaches zero, giving delay+1 waiting cycles.
module circ_src_backoff #(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] delay,
    input  logic             run,
    output logic             wait_over
);
    logic [DLY_W-1:0] cnt;

    // Loads the delay, then counts down while the wait state is active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= delay;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign wait_over = (cnt == '0);
endmodule

// File: rtl/circ_src_pktfmt.sv
// Output word former: puts either the setup packet {target, source} or the
// payload word on the network data lines. Assumes DATA_W >= 2*ADDR_W.
module circ_src_pktfmt #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] SRC_ADDR = '0
) (
    input  logic              sel_setup,
    input  logic              sel_payload,
    input  logic [ADDR_W-1:0] target,
    input  logic [DATA_W-1:0] pay_data,
    output logic [DATA_W-1:0] net_data
);
    localparam int HDR_W = 2 * ADDR_W;
    logic [DATA_W-1:0] header;

    generate
        if (DATA_W > HDR_W) begin : g_pad
            assign header = {{(DATA_W-HDR_W){1'b0}}, target, SRC_ADDR};
        end else begin : g_exact
            assign header = {target, SRC_ADDR};
        end
    endgenerate

    // Selects what drives the data lines this cycle.
    always_comb begin
        if (sel_setup)        net_data = header;
        else if (sel_payload) net_data = pay_data;
        else                  net_data = '0;
    end
endmodule

// File: rtl/circ_src_ctrl.sv
// Source-side controller for a circuit-switched network. It handles one
// transfer at a time: setup packet, wait for the circuit, payload, release,
// and a retry policy for blocked paths. Assumes the payload producer always
// has a word available when pay_take is high.
module circ_src_ctrl
    import circ_src_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8,
    parameter int DLY_W  = 6,
    parameter int CNT_W  = 4,
    parameter logic [ADDR_W-1:0] SRC_ADDR = 5'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_target,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_persist,
    input  logic [DLY_W-1:0]  req_backoff,
    input  logic [DATA_W-1:0] pay_data,
    output logic              pay_take,
    output logic [DATA_W-1:0] net_data,
    output logic              net_setup,
    output logic              net_valid,
    output logic              net_release,
    input  logic              net_ready,
    input  logic              net_blocked,
    output logic              done,
    output logic [CNT_W-1:0]  attempts
);
    localparam logic [CNT_W-1:0] ATT_MAX = '1;

    src_state_t        state;
    logic              retry_pending;
    logic              accept;
    logic              last_word;
    logic              wait_over;
    logic [ADDR_W-1:0] target_q;
    logic              persist_q;
    logic [DLY_W-1:0]  backoff_q;

    assign req_ready   = (state == ST_IDLE);
    assign accept      = req_valid && req_ready;
    assign net_setup   = (state == ST_SEND_SETUP);
    assign net_valid   = (state == ST_PAYLOAD);
    assign pay_take    = net_valid;
    assign net_release = (state == ST_TEARDOWN);
    assign done        = net_release && !retry_pending;

    // Latches the request fields and keeps the attempt count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q  <= '0;
            persist_q <= 1'b0;
            backoff_q <= '0;
            attempts  <= '0;
        end else if (accept) begin
            target_q  <= req_target;
            persist_q <= req_persist;
            backoff_q <= req_backoff;
            attempts  <= 1;
        end else if (state == ST_BACKOFF && wait_over && attempts != ATT_MAX) begin
            attempts  <= attempts + 1'b1;
        end
    end

    circ_src_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (accept),
        .net_ready     (net_ready),
        .net_blocked   (net_blocked),
        .persist       (persist_q),
        .last_word     (last_word),
        .wait_over     (wait_over),
        .state         (state),
        .retry_pending (retry_pending)
    );

    circ_src_lencnt #(.LEN_W(LEN_W)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (accept),
        .len_in    (req_len),
        .load      (state == ST_WAIT_READY && net_ready),
        .step      (net_valid),
        .last_word (last_word)
    );

    circ_src_backoff #(.DLY_W(DLY_W)) u_backoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (net_release && retry_pending),
        .delay     (backoff_q),
        .run       (state == ST_BACKOFF),
        .wait_over (wait_over)
    );

    circ_src_pktfmt #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SRC_ADDR (SRC_ADDR)
    ) u_fmt (
        .sel_setup   (net_setup),
        .sel_payload (net_valid),
        .target      (target_q),
        .pay_data    (pay_data),
        .net_data    (net_data)
    );
endmodule

// File: rtl/circ_src_ctrl_chk.sv
// Protocol checker for circ_src_ctrl, attached to every instance by bind.
module circ_src_ctrl_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             net_setup,
    input logic             net_valid,
    input logic             net_release,
    input logic             net_ready,
    input logic             done,
    input logic [CNT_W-1:0] attempts
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(net_setup || net_valid || net_release)); // R2
    AST_SETUP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        net_setup |=> !net_setup); // R3
    AST_READY_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(net_valid) |-> $past(net_ready)); // R4
    AST_RELEASE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(net_valid) |-> net_release); // R6
    AST_DONE_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> net_release); // R6
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready); // R6
    AST_ATTEMPTS_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> attempts >= $past(attempts)); // R10
endmodule

bind circ_src_ctrl circ_src_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/circ_src_ctrl_bench.sv
module circ_src_ctrl_bench;
    localparam int ADDR_W = 5, DATA_W = 16, LEN_W = 8, DLY_W = 6, CNT_W = 4;
    localparam logic [ADDR_W-1:0] SRC = 5'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_persist = 1'b0;
    logic [ADDR_W-1:0] req_target = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [DLY_W-1:0] req_backoff = '0;
    logic [DATA_W-1:0] pay_data = '0;
    logic net_ready = 1'b0, net_blocked = 1'b0;
    logic req_ready, pay_take, net_setup, net_valid, net_release, done;
    logic [DATA_W-1:0] net_data;
    logic [CNT_W-1:0] attempts;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    circ_src_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
                    .DLY_W(DLY_W), .CNT_W(CNT_W), .SRC_ADDR(SRC)) u_circ_src_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_target(req_target), .req_len(req_len), .req_persist(req_persist),
        .req_backoff(req_backoff), .pay_data(pay_data), .pay_take(pay_take),
        .net_data(net_data), .net_setup(net_setup), .net_valid(net_valid),
        .net_release(net_release), .net_ready(net_ready), .net_blocked(net_blocked),
        .done(done), .attempts(attempts));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change and outputs are read 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Flags packed as {req_ready, net_setup, net_valid, net_release, done}.
    function automatic logic [4:0] flags();
        return {req_ready, net_setup, net_valid, net_release, done};
    endfunction

    task automatic accept_req(input logic [ADDR_W-1:0] tgt, input logic [LEN_W-1:0] len,
                              input logic pers, input logic [DLY_W-1:0] dly);
        req_target = tgt; req_len = len; req_persist = pers; req_backoff = dly;
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
    endtask

    // From the cycle after the ready sample: payload of n words, then release.
    task automatic run_payload(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            pay_data = 16'hA000 + 16'(i);
            #0.1;
            chk({tag, " R5 valid/take"}, {net_valid, pay_take, net_setup}, 3'b110);
            chk({tag, " R5 data"}, net_data, pay_data);
            tick();
        end
        chk({tag, " R6 release+done"}, flags(), 5'b00011);
        tick();
        chk({tag, " R6 idle again"}, flags(), 5'b10000);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        chk("R1 flags", flags(), 5'b10000);
        chk("R1 take", pay_take, 1'b0);
        chk("R1 attempts", attempts, 0);
    endtask

    task automatic t_basic(input logic [ADDR_W-1:0] tgt, input int len);
        accept_req(tgt, LEN_W'(len), 1'b0, 6'd2);
        chk("R3 setup flags", flags(), 5'b01000);
        chk("R3 packet", net_data, {6'd0, tgt, SRC});
        chk("R10 first attempt", attempts, 1);
        tick();
        chk("R3 setup one cycle", flags(), 5'b00000);
        tick(); tick();
        chk("R4 no payload before ready", flags(), 5'b00000);
        net_ready = 1'b1;
        tick();
        net_ready = 1'b0;
        run_payload(len == 0 ? 1 : len, "basic");
        chk("R10 attempts held after done", attempts, 1);
    endtask

    task automatic t_refuse();
        accept_req(5'd9, 8'd2, 1'b0, 6'd0);
        tick();
        req_target = 5'd20; req_valid = 1'b1;
        chk("R2 busy not ready", req_ready, 1'b0);
        net_ready = 1'b1;
        tick();
        net_ready = 1'b0;
        chk("R2 busy during payload", req_ready, 1'b0);
        run_payload(2, "refuse");
        req_valid = 1'b0;
        tick();
        chk("R2 refused request not queued", flags(), 5'b10000);
    endtask

    task automatic t_intermittent(input logic [DLY_W-1:0] dly);
        accept_req(5'd14, 8'd1, 1'b0, dly);
        tick();
        net_blocked = 1'b1;
        tick();
        net_blocked = 1'b0;
        chk("R7 release no done", flags(), 5'b00010);
        for (int i = 0; i <= int'(dly); i++) begin
            tick();
            chk("R7 backoff quiet", flags(), 5'b00000);
        end
        tick();
        chk("R7 setup resent", flags(), 5'b01000);
        chk("R7 packet resent", net_data, {6'd0, 5'd14, SRC});
        chk("R10 attempt count 2", attempts, 2);
        tick();
        net_ready = 1'b1;
        tick();
        net_ready = 1'b0;
        run_payload(1, "intermittent");
    endtask

    task automatic t_persist();
        accept_req(5'd25, 8'd3, 1'b1, 6'd0);
        tick();
        net_blocked = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R8 blocked ignored", flags(), 5'b00000);
        end
        net_ready = 1'b1;
        tick();
        net_ready = 1'b0; net_blocked = 1'b0;
        chk("R8 attempts unchanged", attempts, 1);
        run_payload(3, "persist");
    endtask

    task automatic t_priority();
        accept_req(5'd7, 8'd2, 1'b0, 6'd1);
        tick();
        net_ready = 1'b1; net_blocked = 1'b1;
        tick();
        net_ready = 1'b0; net_blocked = 1'b0;
        chk("R9 ready wins, no release", net_release, 1'b0);
        run_payload(2, "priority");
    endtask

    task automatic t_saturate();
        accept_req(5'd1, 8'd1, 1'b0, 6'd0);
        for (int r = 0; r < 17; r++) begin
            tick();
            net_blocked = 1'b1;
            tick();
            net_blocked = 1'b0;
            tick();
            tick();
        end
        chk("R10 saturated count", attempts, 15);
        tick();
        net_ready = 1'b1;
        tick();
        net_ready = 1'b0;
        run_payload(1, "saturate");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic(5'd17, 4);
        t_basic(5'd30, 0);
        t_refuse();
        t_intermittent(6'd0);
        t_intermittent(6'd5);
        t_persist();
        t_priority();
        t_saturate();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule